// File: doc/BRIEF.md
# Low/Full-Speed USB Packet Transmitter

This block turns a packet, given as a stream of bytes, into the differential line signals of a low-speed or full-speed USB link. The first byte of each packet carries the packet identifier in its low nibble. The block sends a synchronisation pattern, then the identifier and its bitwise complement, then every following byte least significant bit first. Bit stuffing and NRZI coding apply to the whole packet, and a single-ended-zero end-of-packet sequence closes it. CRC fields are not computed here: the source puts them in the byte stream like any other body byte.

Bytes arrive on a valid/ready handshake with a last flag. The packet identifier byte is taken while the transmitter is idle. Each later byte is taken in the clock cycle when the final bit of the byte before it goes onto the line, so the source must hold the next byte valid ahead of that moment. A divider makes the bit-time strobe from the system clock, with one division ratio for full speed and one for low speed. The speed input is sampled when a packet starts and also sets the J/K polarity.

The controller moves through these states: `S_IDLE` (line released), `S_SYNC` (synchronisation byte), `S_BODY` (identifier and body bytes), `S_FLUSH` (a stuffed bit after the final data bit), `S_SE0A` and `S_SE0B` (the two single-ended-zero bit times), `S_EOPJ` (the closing J bit time) and `S_RELEASE` (drop the output enable).

The transitions are:
- idle→sync when a byte is accepted.
- sync→body after the eighth synchronisation bit.
- body→body at each byte boundary where a new byte is taken.
- body→flush or body→se0a when the packet ends. The flush path is taken if six ones have just been sent.
- flush→se0a, se0a→se0b, se0b→eopj, eopj→release and release→idle, each on one bit strobe.

Top module: `usb_pkt_tx`

## Requirements
- R1: After reset and whenever idle, `tx_oe` is 0, the line shows J for the current `low_speed` value (full speed: dp=1 dm=0; low speed: dp=0 dm=1), and `in_ready` is 1.
- R2: Accepting the first byte raises `tx_oe` with the line at J for one bit time. The eight symbols K J K J K J K K follow, which are the NRZI coding of bits 0,0,0,0,0,0,0,1.
- R3: Bits [3:0] of the first byte are sent least significant bit first, followed by their complement, least significant bit first. Bits [7:4] of that byte have no effect on the line.
- R4: Later bytes are sent least significant bit first. `in_ready` is high while `tx_oe` is high only in the clock cycle when a byte's final bit is committed, and the byte is taken if `in_valid` is high in that cycle.
- R5: NRZI coding: a 0 bit toggles the line between J and K, and a 1 bit keeps it.
- R6: After six consecutive 1 bits a 0 bit is inserted. The run count includes the last synchronisation bit, carries across byte boundaries and restarts after each inserted bit. The inserted bit lasts one bit time.
- R7: If the packet's final data bit completes a run of six ones, the inserted 0 bit is sent before the end-of-packet sequence.
- R8: A packet ends with exactly two bit times of SE0 (dp=0 dm=0), then one bit time of J. `tx_oe` falls at the following bit boundary.
- R9: One bit time is `FS_DIV` clocks when `low_speed` was 0 at packet start and `LS_DIV` clocks when it was 1. At low speed the J and K levels are swapped.
- R10: If `in_valid` is low when the next byte is due, the packet ends as if the previous byte had been flagged last.
- R11: dp and dm are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| low_speed | input | 1 | 1 selects low speed, 0 full speed; sampled at packet start |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_data | input | 8 | Packet byte; identifier in [3:0] of the first byte |
| in_last | input | 1 | Marks the final byte of the packet |
| in_ready | output | 1 | Byte accepted in this cycle if `in_valid` is high |
| tx_oe | output | 1 | Transmitter drives the line |
| tx_dp | output | 1 | D+ line level |
| tx_dm | output | 1 | D- line level |

## Verification
The checker watches every cycle for the absence of SE1 and for the J line while released. It also checks that no more than six bit times pass without a transition, that SE0 lasts exactly two bit strobes, and that the ready pulse happens only on a bit strobe during a packet. Only the scenarios show the exact symbol order: the synchronisation pattern, identifier complementing, least-significant-bit-first body order, and stuffing at byte boundaries and before the end of packet. They also cover the early end on a missing byte and the low-speed timing and polarity. Each scenario compares every bit window against a symbol list built from the requirements.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SYNC,
        S_BODY,
        S_FLUSH,
        S_SE0A,
        S_SE0B,
        S_EOPJ,
        S_RELEASE
    } tx_state_t;

    typedef enum logic [2:0] {
        LC_HOLD,
        LC_START,
        LC_BIT,
        LC_SE0,
        LC_J,
        LC_OFF
    } line_cmd_t;

    // Synchronisation byte as bits sent LSB first: seven zeros then a one.
    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam int         STUFF_RUN = 6;

endpackage

// File: rtl/usb_tx_baud.sv
module usb_tx_baud #(
    parameter int FS_DIV = 4,
    parameter int LS_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic bit_stb
);
    localparam int MAXDIV = (LS_DIV > FS_DIV) ? LS_DIV : FS_DIV;
    localparam int CW     = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;
    localparam logic [CW-1:0] FS_LIM = CW'(FS_DIV - 1);
    localparam logic [CW-1:0] LS_LIM = CW'(LS_DIV - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim     = slow ? LS_LIM : FS_LIM;
    assign bit_stb = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || bit_stb) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/usb_tx_line.sv
module usb_tx_line
    import usb_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_cmd_t cmd,
    input  logic      bit_in,
    input  logic      slow,
    output logic      tx_oe,
    output logic      tx_dp,
    output logic      tx_dm
);
    logic oe_q;
    logic se0_q;
    logic lvl_q;   // 1 = J, 0 = K

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q  <= 1'b0;
            se0_q <= 1'b0;
            lvl_q <= 1'b1;
        end else begin
            case (cmd)
                LC_START: begin
                    oe_q  <= 1'b1;
                    se0_q <= 1'b0;
                    lvl_q <= 1'b1;
                end
                LC_BIT:  lvl_q <= bit_in ? lvl_q : ~lvl_q;
                LC_SE0:  se0_q <= 1'b1;
                LC_J: begin
                    se0_q <= 1'b0;
                    lvl_q <= 1'b1;
                end
                LC_OFF: begin
                    oe_q  <= 1'b0;
                    se0_q <= 1'b0;
                    lvl_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign tx_oe = oe_q;
    assign tx_dp = !se0_q && (lvl_q ^ slow);
    assign tx_dm = !se0_q && !(lvl_q ^ slow);
endmodule

// File: rtl/usb_pkt_tx.sv
module usb_pkt_tx
    import usb_tx_pkg::*;
#(
    parameter int FS_DIV = 4,
    parameter int LS_DIV = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       low_speed,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       tx_oe,
    output logic       tx_dp,
    output logic       tx_dm
);
    localparam int RW = $clog2(STUFF_RUN + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(STUFF_RUN);

    tx_state_t      state, nstate;
    line_cmd_t      cmd;
    logic           bit_out;
    logic           bit_stb;
    logic           ls_q;
    logic           slow;
    logic [7:0]     sh;
    logic [2:0]     bcnt;
    logic [RW-1:0]  run, next_run;
    logic           cur_last;
    logic [3:0]     pid_q;
    logic           pid_last_q;
    logic           stuff_now;
    logic           byte_end;
    logic           take;
    logic           shifting;

    assign slow      = (state == S_IDLE) ? low_speed : ls_q;
    assign stuff_now = (run == RUN_MAX);
    assign shifting  = (state == S_SYNC) || (state == S_BODY);
    assign byte_end  = shifting && bit_stb && !stuff_now && (bcnt == 3'd7);
    assign take      = in_valid && in_ready;
    assign next_run  = stuff_now ? '0 : (sh[0] ? run + 1'b1 : '0);

    usb_tx_baud #(.FS_DIV(FS_DIV), .LS_DIV(LS_DIV)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state != S_IDLE),
        .slow    (slow),
        .bit_stb (bit_stb)
    );

    usb_tx_line u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .bit_in (bit_out),
        .slow   (slow),
        .tx_oe  (tx_oe),
        .tx_dp  (tx_dp),
        .tx_dm  (tx_dm)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // Next state and outputs
    always_comb begin
        nstate   = state;
        cmd      = LC_HOLD;
        bit_out  = 1'b0;
        in_ready = 1'b0;
        unique case (state)
            S_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    cmd    = LC_START;
                    nstate = S_SYNC;
                end
            end
            S_SYNC: begin
                if (bit_stb) begin
                    cmd     = LC_BIT;
                    bit_out = !stuff_now && sh[0];
                end
                if (byte_end) nstate = S_BODY;
            end
            S_BODY: begin
                if (bit_stb) begin
                    cmd     = LC_BIT;
                    bit_out = !stuff_now && sh[0];
                end
                in_ready = byte_end && !cur_last;
                if (byte_end && (cur_last || !in_valid)) begin
                    nstate = (next_run == RUN_MAX) ? S_FLUSH : S_SE0A;
                end
            end
            S_FLUSH: begin
                if (bit_stb) begin
                    cmd    = LC_BIT;
                    nstate = S_SE0A;
                end
            end
            S_SE0A: begin
                if (bit_stb) begin
                    cmd    = LC_SE0;
                    nstate = S_SE0B;
                end
            end
            S_SE0B: begin
                if (bit_stb) nstate = S_EOPJ;
            end
            S_EOPJ: begin
                if (bit_stb) begin
                    cmd    = LC_J;
                    nstate = S_RELEASE;
                end
            end
            S_RELEASE: begin
                if (bit_stb) begin
                    cmd    = LC_OFF;
                    nstate = S_IDLE;
                end
            end
            default: nstate = S_IDLE;
        endcase
    end

    // Shift path, run counter and held identifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh         <= '0;
            bcnt       <= '0;
            run        <= '0;
            cur_last   <= 1'b0;
            pid_q      <= '0;
            pid_last_q <= 1'b0;
            ls_q       <= 1'b0;
        end else if (state == S_IDLE) begin
            if (in_valid) begin
                pid_q      <= in_data[3:0];
                pid_last_q <= in_last;
                ls_q       <= low_speed;
                sh         <= SYNC_BYTE;
                bcnt       <= '0;
                run        <= '0;
                cur_last   <= 1'b0;
            end
        end else if (shifting && bit_stb) begin
            run <= next_run;
            if (!stuff_now) begin
                sh   <= sh >> 1;
                bcnt <= bcnt + 1'b1;
                if (byte_end && state == S_SYNC) begin
                    sh       <= {~pid_q, pid_q};
                    cur_last <= pid_last_q;
                end else if (byte_end && take) begin
                    sh       <= in_data;
                    cur_last <= in_last;
                end
            end
        end else if (state == S_FLUSH && bit_stb) begin
            run <= '0;
        end
    end
endmodule

// File: rtl/usb_pkt_tx_chk.sv
module usb_pkt_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic low_speed,
    input logic in_ready,
    input logic tx_oe,
    input logic tx_dp,
    input logic tx_dm,
    input logic bit_stb
);
    logic       se0_ln;
    logic       prev_dp;
    logic [3:0] same_cnt;
    logic [1:0] se0_cnt;

    assign se0_ln = tx_oe && !tx_dp && !tx_dm;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_dp  <= 1'b0;
            same_cnt <= '0;
            se0_cnt  <= '0;
        end else begin
            if (bit_stb) begin
                prev_dp <= tx_dp;
                if (!tx_oe || se0_ln)        same_cnt <= '0;
                else if (tx_dp == prev_dp)   same_cnt <= same_cnt + 1'b1;
                else                         same_cnt <= '0;
            end
            if (!se0_ln)      se0_cnt <= '0;
            else if (bit_stb) se0_cnt <= se0_cnt + 1'b1;
        end
    end

    assert_no_se1_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_dp && tx_dm));

    assert_idle_j_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> (tx_dp == !low_speed) && (tx_dm == low_speed));

    assert_run_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        same_cnt <= 4'd6);

    assert_eop_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(se0_ln) |-> (se0_cnt == 2'd2));

    assert_ready_on_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && tx_oe) |-> bit_stb);
endmodule

bind usb_pkt_tx usb_pkt_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .low_speed (low_speed),
    .in_ready  (in_ready),
    .tx_oe     (tx_oe),
    .tx_dp     (tx_dp),
    .tx_dm     (tx_dm),
    .bit_stb   (bit_stb)
);

// File: tb/usb_pkt_tx_tb.sv
module usb_pkt_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FS_DIV     = 4;
    localparam int LS_DIV     = 32;

    typedef struct {
        logic [2:0] v;      // {oe, dp, dm}
        string      tag;
        int         div;
    } sym_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       low_speed = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       tx_oe, tx_dp, tx_dm;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    sym_t sq[$];
    logic [7:0] pkt [0:15];

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_pkt_tx #(.FS_DIV(FS_DIV), .LS_DIV(LS_DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .low_speed(low_speed),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .tx_oe(tx_oe), .tx_dp(tx_dp), .tx_dm(tx_dm)
    );

    task automatic chk(input logic ok, input string tag, input logic [2:0] got, input logic [2:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Builds the expected symbol list from the requirements and pushes it.
    // pid_byte: first byte; nb: body bytes sent from pkt[]; ls: speed;
    // tail_tag names the requirement behind the packet's end.
    task automatic expect_packet(input logic [7:0] pid_byte, input int nb, input logic ls, input string tail_tag);
        int         bits[$];
        string      tags[$];
        logic [1:0] jp, kp;
        logic       lvl;
        int         run;
        int         d;
        string      sfx;
        sym_t       s;
        jp  = ls ? 2'b01 : 2'b10;
        kp  = ~jp;
        d   = ls ? LS_DIV : FS_DIV;
        sfx = ls ? "/R9" : "";
        for (int i = 0; i < 8; i++) begin bits.push_back(i == 7); tags.push_back("R2"); end
        for (int i = 0; i < 4; i++) begin bits.push_back(int'(pid_byte[i]));  tags.push_back("R3"); end
        for (int i = 0; i < 4; i++) begin bits.push_back(int'(!pid_byte[i])); tags.push_back("R3"); end
        for (int b = 0; b < nb; b++)
            for (int i = 0; i < 8; i++) begin bits.push_back(int'(pkt[b][i])); tags.push_back("R4"); end
        lvl = 1'b1;
        run = 0;
        s.div = d;
        s.v = {1'b1, jp}; s.tag = {"R2 lead-in J", sfx}; sq.push_back(s);
        for (int i = 0; i < bits.size(); i++) begin
            if (bits[i] == 0) lvl = ~lvl;
            s.v = {1'b1, lvl ? jp : kp}; s.tag = {tags[i], "/R5", sfx}; sq.push_back(s);
            run = (bits[i] != 0) ? run + 1 : 0;
            if (run == 6) begin
                lvl = ~lvl;
                s.v = {1'b1, lvl ? jp : kp};
                s.tag = {(i == bits.size() - 1) ? "R7 final stuff" : "R6 stuff", sfx};
                sq.push_back(s);
                run = 0;
            end
        end
        s.v = 3'b100; s.tag = {tail_tag, " SE0", sfx}; sq.push_back(s);
        s.v = 3'b100; s.tag = {tail_tag, " SE0", sfx}; sq.push_back(s);
        s.v = {1'b1, jp}; s.tag = {tail_tag, " J", sfx}; sq.push_back(s);
        s.v = {1'b0, jp}; s.tag = {tail_tag, " release", sfx}; sq.push_back(s);
    endtask

    // Called at a negedge; returns at the negedge after acceptance.
    task automatic put_byte(input logic [7:0] d, input logic last);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_packet(input logic [7:0] pid_byte, input int nb, input logic ls,
                               input bit underrun, input string tail_tag);
        @(negedge clk);
        low_speed = ls;
        expect_packet(pid_byte, nb, ls, tail_tag);
        put_byte(pid_byte, (nb == 0) && !underrun);
        for (int b = 0; b < nb; b++) put_byte(pkt[b], (b == nb - 1) && !underrun);
        in_valid = 1'b0;
        in_last  = 1'b0;
        wait (sq.size() == 0);
        repeat (5) @(negedge clk);
    endtask

    // Monitor: one sample in the middle of every bit window
    initial begin
        sym_t it;
        forever begin
            @(negedge clk);
            if (tx_oe && sq.size() > 0) begin
                repeat (sq[0].div / 2) @(negedge clk);
                forever begin
                    it = sq.pop_front();
                    // R11 also covered: an SE1 never matches an expected symbol
                    chk({tx_oe, tx_dp, tx_dm} === it.v, it.tag, {tx_oe, tx_dp, tx_dm}, it.v);
                    if (!it.v[2]) break;
                    repeat (it.div) @(negedge clk);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired, got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during and after reset
        chk({tx_oe, tx_dp, tx_dm} == 3'b010, "R1 reset line", {tx_oe, tx_dp, tx_dm}, 3'b010);
        rst_n = 1'b1;
        @(negedge clk);
        chk({tx_oe, tx_dp, tx_dm} == 3'b010, "R1 idle fs", {tx_oe, tx_dp, tx_dm}, 3'b010);
        chk(in_ready == 1'b1, "R1 ready idle", {2'b0, in_ready}, 3'b001);
        low_speed = 1'b1;
        @(negedge clk);
        chk({tx_oe, tx_dp, tx_dm} == 3'b001, "R1 idle ls", {tx_oe, tx_dp, tx_dm}, 3'b001);
        low_speed = 1'b0;

        // Handshake: identifier 0010 with junk in the upper nibble (R3)
        send_packet(8'h52, 0, 1'b0, 1'b0, "R8");

        // Token: SETUP with address/endpoint/CRC bytes
        pkt[0] = 8'h81; pkt[1] = 8'h3A;
        send_packet(8'h0D, 2, 1'b0, 1'b0, "R8");

        // Data: runs of ones across byte boundaries (R6), final run of six (R7)
        pkt[0] = 8'hFF; pkt[1] = 8'h7F; pkt[2] = 8'hC3; pkt[3] = 8'hFC;
        send_packet(8'hC3, 4, 1'b0, 1'b0, "R8");

        // Low speed packet (R9)
        pkt[0] = 8'hA5; pkt[1] = 8'h3F;
        send_packet(8'h4B, 2, 1'b1, 1'b0, "R8");

        // Missing byte ends the packet early (R10)
        pkt[0] = 8'h12; pkt[1] = 8'hFE;
        send_packet(8'h69, 2, 1'b0, 1'b1, "R10");

        @(negedge clk);
        chk({tx_oe, tx_dp, tx_dm} == 3'b010, "R1 idle after packets", {tx_oe, tx_dp, tx_dm}, 3'b010);
        chk(in_ready == 1'b1, "R1 ready after packets", {2'b0, in_ready}, 3'b001);
        finish_run();
    end
endmodule